// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block turns one slow multiplying DAC channel and an external single-bit comparator into a 12-bit analog-to-digital converter. The comparator reports whether the unknown input lies above the voltage the DAC is producing. A start pulse begins a conversion. The controller then tests the code bits one at a time, from the most significant down to the least significant. For each bit it writes a trial code to the DAC and waits long enough for the DAC and comparator to settle. It then reads the synchronised comparator level and either keeps or drops the bit under test.

The DAC uses offset-binary coding, so the first trial is always mid-scale, the analog zero point. The settling wait is derived from the clock frequency so that at least 15 µs pass between a DAC write and the comparator sample that depends on it. At 1 MHz a full conversion takes 204 cycles. When the last bit has been decided, the final code appears on the result output together with a one-cycle done pulse.

Top module: `sar_dac_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, dac_code_o, result_o, dac_wr_o and done_o are all zero.
- R2: A start_i level seen high on a clock edge while idle raises dac_wr_o for exactly one cycle, starting in the next cycle. In that cycle dac_code_o is 0x800, which has only bit 11 set.
- R3: For each trial, cmp_i = 1 means the input is above the DAC code and keeps the bit under test; cmp_i = 0 clears it. The next lower bit is then set for the following trial. The final result is the largest 12-bit code strictly below the input, or 0 if there is none.
- R4: The settle count is S = ceil(SETTLE_NS × CLK_HZ / 1e9), with a minimum of 1. Each later trial write follows the previous one by exactly S + 2 cycles, and a conversion makes exactly 12 writes.
- R5: done_o is high for exactly one cycle, 12 × (S + 2) cycles after the accepting start edge. result_o carries the new result in that cycle.
- R6: A start_i pulse during a conversion changes neither the number nor the timing of the trial writes, nor the result.
- R7: result_o changes only in a done cycle. After done, dac_code_o keeps the final code until the next start.
- R8: cmp_i passes through a two-flop synchroniser. A bit decision uses the cmp_i level present at the clock edge two cycles before the decision edge. A level present only in the last two cycles before the decision edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a conversion; sampled only while idle |
| cmp_i | input | 1 | Asynchronous comparator: 1 when the input is above the DAC output |
| dac_code_o | output | 12 | Offset-binary code for the DAC channel |
| dac_wr_o | output | 1 | One-cycle strobe that writes dac_code_o into the DAC |
| result_o | output | 12 | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
A wrong bit mask or a wrong keep/clear decision appears on dac_code_o at the very next trial write. That is at most S + 2 cycles after the fault, long before the result is complete. A timer or synchroniser fault shifts the write strobes or the done pulse away from their fixed cycle positions. The bench pins those positions down to the cycle, and it injects comparator levels in chosen cycles to expose a synchroniser of the wrong depth. A stray restart would show as an extra write strobe or a late done pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [0:0] {
    SAR_IDLE  = 1'b0,
    SAR_TRIAL = 1'b1
  } sar_state_e;

  // Settling cycles rounded up so the wall-clock wait is never short.
  function automatic int unsigned settle_cycles(input int unsigned ns,
                                                input int unsigned hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = 64'(ns) * 64'(hz);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 64'd1) cyc = 64'd1;
    return int'(cyc);
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_n = value_i;
    else        cnt_n = cnt_q - WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int unsigned BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init_i,
  input  logic            step_i,
  input  logic            keep_i,
  output logic [BITS-1:0] code_o,
  output logic [BITS-1:0] code_nxt_o,
  output logic            last_o
);

  localparam logic [BITS-1:0] TOP_BIT = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] code_q, code_n;
  logic [BITS-1:0] mask_q, mask_n;
  logic            upd_en;

  always_comb begin
    upd_en = init_i || step_i;
    code_n = code_q;
    mask_n = mask_q;
    if (init_i) begin
      code_n = TOP_BIT;
      mask_n = TOP_BIT;
    end else if (step_i) begin
      code_n = keep_i ? code_q : (code_q & ~mask_q);
      mask_n = mask_q >> 1;
      code_n = code_n | mask_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      code_q <= code_n;
      mask_q <= mask_n;
    end
  end

  assign code_o     = code_q;
  assign code_nxt_o = code_n;
  assign last_o     = mask_q[0];

endmodule

// File: rtl/sar_dac_ctrl.sv
module sar_dac_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned BITS       = 12,
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_NS  = 15_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            cmp_i,
  output logic [BITS-1:0] dac_code_o,
  output logic            dac_wr_o,
  output logic [BITS-1:0] result_o,
  output logic            done_o
);

  localparam int unsigned SETTLE_CYC = settle_cycles(SETTLE_NS, CLK_HZ);
  localparam int unsigned WAIT       = SETTLE_CYC + SYNC_STAGES;
  localparam int unsigned TW         = (WAIT > 2) ? $clog2(WAIT) : 2;
  localparam logic [TW-1:0] LOAD_V   = TW'(WAIT - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // Datapath pieces
  logic            cmp_sync;
  logic            tmr_zero;
  logic            tmr_load;
  logic            ap_init, ap_step, ap_last;
  logic [BITS-1:0] ap_code, ap_code_nxt;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_q_n),
    .d_i  (cmp_i),
    .q_o  (cmp_sync)
  );

  sar_timer #(.WIDTH(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (tmr_load),
    .value_i(LOAD_V),
    .zero_o (tmr_zero)
  );

  sar_approx #(.BITS(BITS)) u_approx (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .init_i    (ap_init),
    .step_i    (ap_step),
    .keep_i    (cmp_sync),
    .code_o    (ap_code),
    .code_nxt_o(ap_code_nxt),
    .last_o    (ap_last)
  );

  // Control state
  sar_state_e      st_q, st_n;
  logic            wr_q, wr_n;
  logic            done_q, done_n;
  logic [BITS-1:0] res_q;
  logic            res_en;
  logic            busy;

  always_comb begin
    st_n     = st_q;
    wr_n     = 1'b0;
    done_n   = 1'b0;
    res_en   = 1'b0;
    tmr_load = 1'b0;
    ap_init  = 1'b0;
    ap_step  = 1'b0;
    unique case (st_q)
      SAR_IDLE: begin
        if (start_i) begin
          ap_init  = 1'b1;
          tmr_load = 1'b1;
          wr_n     = 1'b1;
          st_n     = SAR_TRIAL;
        end
      end
      SAR_TRIAL: begin
        if (tmr_zero) begin
          ap_step = 1'b1;
          if (ap_last) begin
            res_en = 1'b1;
            done_n = 1'b1;
            st_n   = SAR_IDLE;
          end else begin
            tmr_load = 1'b1;
            wr_n     = 1'b1;
          end
        end
      end
      default: st_n = SAR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= SAR_IDLE;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wr_q   <= wr_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    res_q <= '0;
    else if (res_en) res_q <= ap_code_nxt;
  end

  assign busy       = (st_q == SAR_TRIAL);
  assign dac_code_o = ap_code;
  assign dac_wr_o   = wr_q;
  assign result_o   = res_q;
  assign done_o     = done_q;

endmodule

// File: rtl/sar_dac_ctrl_chk.sv
module sar_dac_ctrl_chk #(
  parameter int unsigned BITS = 12,
  parameter int unsigned WAIT = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            start_i,
  input logic [BITS-1:0] dac_code_o,
  input logic            dac_wr_o,
  input logic [BITS-1:0] result_o,
  input logic            done_o
);

  localparam int unsigned GW = $clog2(WAIT + 2);
  localparam logic [BITS-1:0] MID = {1'b1, {(BITS-1){1'b0}}};

  // Cycles since the last write strobe, saturating.
  logic [GW-1:0] gap_q;
  logic          accept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      accept_q <= 1'b0;
    end else begin
      accept_q <= !busy && start_i;
      if (dac_wr_o)                      gap_q <= GW'(1);
      else if (gap_q != GW'(WAIT + 1))   gap_q <= gap_q + GW'(1);
    end
  end

  // R2: accepted start yields a mid-scale write in the next cycle
  a_r2_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (dac_wr_o && dac_code_o == MID));

  // R2: the write strobe lasts one cycle
  a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr_o |=> !dac_wr_o);

  // R4: later trial writes are spaced by the full wait
  a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_wr_o && !accept_q) |-> (gap_q == GW'(WAIT)));

  // R5: done is a single-cycle pulse and ends the conversion
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

  // R7: result only moves in a done cycle
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  // R7: DAC code holds while idle and no start arrives
  a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(dac_code_o));

endmodule

bind sar_dac_ctrl sar_dac_ctrl_chk #(.BITS(BITS), .WAIT(WAIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .busy      (busy),
  .start_i   (start_i),
  .dac_code_o(dac_code_o),
  .dac_wr_o  (dac_wr_o),
  .result_o  (result_o),
  .done_o    (done_o)
);

// File: tb/sar_dac_ctrl_bench.sv
module sar_dac_ctrl_bench;

  localparam int CLK_PERIOD = 1000;          // 1 MHz, in ns
  localparam int CLK_HZ     = 1_000_000;
  localparam int SETTLE_NS  = 15_000;
  localparam int S          = 15;            // ceil(15 us * 1 MHz)
  localparam int W          = S + 2;         // cycles between trial writes
  localparam int DONE_K     = 12 * W + 1;    // negedge index where done shows
  localparam int NVEC       = 8;

  localparam int VIN_T [NVEC] = '{0, 1, 2, 2048, 2049, 2730, 4095, 4096};
  localparam int EXP_T [NVEC] = '{0, 0, 1, 2047, 2048, 2729, 4094, 4095};

  logic        clk, rst_n, start_i, cmp_i;
  logic [11:0] dac_code_o, result_o;
  logic        dac_wr_o, done_o;

  int  n_chk, n_bad;
  bit  finished;

  sar_dac_ctrl #(
    .BITS(12), .CLK_HZ(CLK_HZ), .SETTLE_NS(SETTLE_NS), .SYNC_STAGES(2)
  ) u_sar_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .dac_wr_o(dac_wr_o),
    .result_o(result_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One conversion. mode 0: comparator models the input level;
  // mode 1: comparator high only in the two cycles before each decision;
  // mode 2: comparator high only at the edge two cycles before each decision.
  task automatic convert(input int vin, input int mode, input int exp_res,
                         input bit poke);
    int  k, nwr, done_at, wr_bad, hold_bad;
    logic [11:0] held;
    held = result_o;
    nwr = 0; done_at = -1; wr_bad = 0; hold_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    cmp_i   = 1'b0;
    for (k = 1; k <= DONE_K + 20; k++) begin
      @(negedge clk);
      start_i = (poke && (k == 50 || k == 51)) ? 1'b1 : 1'b0;
      case (mode)
        0:       cmp_i = (vin > int'(dac_code_o));
        1:       cmp_i = ((k % W) == W-1) || ((k % W) == 0);
        default: cmp_i = ((k % W) == W-2);
      endcase
      if (dac_wr_o) begin
        nwr++;
        if (k != 1 + W*(nwr-1)) wr_bad++;
        if (nwr == 1) check(dac_code_o == 12'h800, "R2 first trial code",
                            int'(dac_code_o), 'h800);
      end
      if (done_o) begin
        done_at = k;
        break;
      end
      if (result_o != held) hold_bad++;
    end
    check(wr_bad == 0, poke ? "R6 write timing under restart" : "R4 write spacing",
          wr_bad, 0);
    check(nwr == 12, poke ? "R6 write count under restart" : "R4 write count", nwr, 12);
    check(done_at == DONE_K, "R5 done latency", done_at, DONE_K);
    check(int'(result_o) == exp_res,
          (mode == 0) ? "R3 result" : "R8 sync sample point",
          int'(result_o), exp_res);
    check(hold_bad == 0, "R7 result held during conversion", hold_bad, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(int'(result_o) == exp_res, "R7 result held after done", int'(result_o), exp_res);
    check(int'(dac_code_o) == exp_res, "R7 dac code holds final", int'(dac_code_o), exp_res);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    start_i = 1'b0; cmp_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dac_code_o == 0 && result_o == 0, "R1 codes in reset",
          int'(dac_code_o) + int'(result_o), 0);
    check(!dac_wr_o && !done_o, "R1 strobes in reset",
          int'(dac_wr_o) + int'(done_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(dac_code_o == 0 && !dac_wr_o && !done_o, "R1 idle after release",
          int'(dac_code_o), 0);

    for (int i = 0; i < NVEC; i++) convert(VIN_T[i], 0, EXP_T[i], 1'b0);

    // R6: start pulse mid-conversion ignored
    convert(1000, 0, 999, 1'b1);

    // R8: synchroniser depth and sample point
    convert(0, 1, 0, 1'b0);
    convert(0, 2, 4095, 1'b0);

    // R1: reset in the middle of a conversion
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dac_code_o == 0 && result_o == 0 && !dac_wr_o && !done_o,
          "R1 mid-conversion reset", int'(dac_code_o) + int'(result_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    convert(3000, 0, 2999, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule